// File: doc/BRIEF.md
# PWM Fault Break Shutdown Controller

This block sits between a complementary PWM generator and the output pins of a power stage. While the outputs are enabled, each high-side/low-side pair passes straight through. When a fault is seen, the block withdraws the output enable and drives every pair to a safe state. Two break channels watch the faults. The primary channel gathers an external pin, a set of internal comparator lines and an always-active-high system fault. The secondary channel gathers a second external pin and its own comparator lines.

The two channels differ in the safe state they apply. The secondary channel only turns every switch off. The primary channel first turns everything off for a programmed dead time, and then drives each pair to its programmed idle levels. When both channels are active, the primary channel wins. Each pin and comparator source has its own polarity bit. Each channel has a digital glitch filter whose window runs up to 256 clock ticks. The system fault skips both the polarity bit and the filter. After a break, the outputs come back either on an update-event strobe (when automatic re-enable is set) or on a manual request. A manual request is refused while a sticky break flag is still set. Writing a non-zero lock level freezes the whole configuration until reset.

Top module: `pwm_break_guard`

## Requirements
- R1: A channel's break condition is the OR of its external pin and its comparator lines, each first passed through its own polarity bit (1 = active high, 0 = active low), and the whole OR is gated by that channel's enable bit.
- R2: The system fault input counts as a primary break when the primary enable bit is 1, with no polarity and no filter. A single-cycle pulse drops the output enable after the second rising edge. With the primary enable bit at 0 it has no effect.
- R3: Filter code 0 passes a condition seen at one edge. A code c of 1 to 15 requires 16*(c+1) consecutive asserted samples, so code 15 means 256. One deasserted sample restarts the count, and a shorter condition leaves the outputs untouched.
- R4: A break condition present from edge k (with filter code 0) drops outEn after edge k+1. From that edge on, all outputs are 0 for the programmed dead-time count of cycles, and then each pair shows its idle levels.
- R5: A secondary break alone drops outEn and forces every high and low output to 0.
- R6: While both channels are active, the outputs show the primary idle levels. Once the primary clears and the secondary stays active, the outputs return to 0.
- R7: With automatic re-enable set, outEn returns at the first update strobe that finds both channels clear. With it cleared, update strobes leave outEn at 0. An update strobe during an active break has no effect.
- R8: Each channel has a sticky flag (priFlag, secFlag) that is set by its break. It is cleared by flagClr bit 0 (primary) or bit 1 (secondary) once that break is gone. oeSetReq sets outEn only while both flags are 0 and neither break is active.
- R9: After a configuration write with a non-zero lock level, later configuration writes are ignored until reset, including writes to the lock field. Reset removes the lock.
- R10: An unused pin reads as 0. With its polarity at 0 (active low) and its channel enabled, this is a break.
- R11: After reset, outEn, both flags and all outputs are 0, all enables are off and all polarities are active high. While outEn is 1, every output equals its PWM input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the filter ticks once per cycle |
| rstN | input | 1 | Active-low synchronous reset |
| pwmHiIn | input | NUM_PAIRS | High-side PWM from the generator |
| pwmLoIn | input | NUM_PAIRS | Low-side PWM from the generator |
| extPin | input | 1 | Primary external break pin |
| extPin2 | input | 1 | Secondary external break pin |
| cmpPri | input | NUM_CMP | Comparator lines feeding the primary channel |
| cmpSec | input | NUM_CMP | Comparator lines feeding the secondary channel |
| sysFault | input | 1 | System fault, always active high |
| cfgWr | input | 1 | Configuration write strobe |
| cfgPriEn | input | 1 | Primary channel enable (also enables sysFault) |
| cfgSecEn | input | 1 | Secondary channel enable |
| cfgPinPol | input | 1 | Polarity of extPin |
| cfgPin2Pol | input | 1 | Polarity of extPin2 |
| cfgCmpPriPol | input | NUM_CMP | Polarity of each primary comparator line |
| cfgCmpSecPol | input | NUM_CMP | Polarity of each secondary comparator line |
| cfgPriFilt | input | 4 | Primary filter code |
| cfgSecFilt | input | 4 | Secondary filter code |
| cfgDeadTime | input | DT_W | Blanking cycles before idle levels apply |
| cfgAutoOe | input | 1 | Automatic re-enable on update strobe |
| cfgIdleHi | input | NUM_PAIRS | Idle level of each high-side output |
| cfgIdleLo | input | NUM_PAIRS | Idle level of each low-side output |
| cfgLock | input | 2 | Lock level; non-zero freezes configuration |
| updateEvt | input | 1 | Update-event strobe from the PWM counter |
| oeSetReq | input | 1 | Manual output-enable request |
| flagClr | input | 2 | Flag clear: bit 0 primary, bit 1 secondary |
| pwmHiOut | output | NUM_PAIRS | Gated high-side outputs |
| pwmLoOut | output | NUM_PAIRS | Gated low-side outputs |
| outEn | output | 1 | Outputs currently passing PWM |
| priFlag | output | 1 | Sticky primary break flag |
| secFlag | output | 1 | Sticky secondary break flag |

## Verification
The source-combining logic is exercised with random mixes of pin levels, comparator levels, polarities and enables. Each trial shows whether the OR and the per-source polarity are right, and whether the resulting safe state (idle, all-off or pass-through) follows the channel that fired. Directed runs hold a condition for one tick less than the filter window, for exactly the window, and with a single dropped sample. These runs separate a correct window length from an off-by-one count or a count that fails to restart. Further sequences overlap the two channels, pulse the system fault, and try to re-enable while a flag is set or after a lock. These show the priority, the filter bypass, the blocking of manual requests and the frozen configuration.

// File: rtl/brk_guard_pkg.sv
`timescale 1ns/1ps
package brk_guard_pkg;

  localparam int NUM_CH      = 2;
  localparam int FILT_CODE_W = 4;
  localparam int FILT_CNT_W  = 9;

  // Control-to-datapath strobes
  typedef struct packed {
    logic outEn;     // pass PWM through
    logic idleMode;  // safe state is programmed idle levels
    logic dtHold;    // dead-time blanking still running
  } guard_strobe_t;

  // Filter window length for a code: 0 -> 1 sample, c -> 16*(c+1)
  function automatic logic [FILT_CNT_W-1:0] filtLen(input logic [FILT_CODE_W-1:0] code);
    logic [FILT_CNT_W-1:0] wide;
    wide = FILT_CNT_W'(code) + FILT_CNT_W'(1);
    if (code == '0) return FILT_CNT_W'(1);
    return wide << 4;
  endfunction

endpackage

// File: rtl/brk_glitch_filter.sv
`timescale 1ns/1ps
module brk_glitch_filter
  import brk_guard_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   sampleIn,
  input  logic [FILT_CODE_W-1:0] lenCode,
  output logic                   hit
);

  logic [FILT_CNT_W-1:0] runCnt;
  logic [FILT_CNT_W-1:0] runLen;

  assign runLen = filtLen(lenCode);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runCnt <= '0;
    end else if (!sampleIn) begin
      runCnt <= '0;
    end else if (runCnt < runLen) begin
      runCnt <= runCnt + FILT_CNT_W'(1);
    end
  end

  assign hit = (runCnt >= runLen);

endmodule

// File: rtl/brk_datapath.sv
`timescale 1ns/1ps
module brk_datapath
  import brk_guard_pkg::*;
#(
  parameter int NUM_PAIRS = 3,
  parameter int NUM_CMP   = 2,
  parameter int DT_W      = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_PAIRS-1:0]   pwmHiIn,
  input  logic [NUM_PAIRS-1:0]   pwmLoIn,
  input  logic                   extPin,
  input  logic                   extPin2,
  input  logic [NUM_CMP-1:0]     cmpPri,
  input  logic [NUM_CMP-1:0]     cmpSec,
  input  logic                   sysFault,
  input  logic                   cfgWr,
  input  logic                   cfgPriEn,
  input  logic                   cfgSecEn,
  input  logic                   cfgPinPol,
  input  logic                   cfgPin2Pol,
  input  logic [NUM_CMP-1:0]     cfgCmpPriPol,
  input  logic [NUM_CMP-1:0]     cfgCmpSecPol,
  input  logic [FILT_CODE_W-1:0] cfgPriFilt,
  input  logic [FILT_CODE_W-1:0] cfgSecFilt,
  input  logic [DT_W-1:0]        cfgDeadTime,
  input  logic                   cfgAutoOe,
  input  logic [NUM_PAIRS-1:0]   cfgIdleHi,
  input  logic [NUM_PAIRS-1:0]   cfgIdleLo,
  input  logic [1:0]             cfgLock,
  input  guard_strobe_t          strobe,
  output logic                   trigPri,
  output logic                   trigSec,
  output logic [DT_W-1:0]        deadTime,
  output logic                   autoOe,
  output logic [NUM_PAIRS-1:0]   pwmHiOut,
  output logic [NUM_PAIRS-1:0]   pwmLoOut
);

  // Configuration registers, frozen once a lock level is stored
  logic                   priEnQ, secEnQ, pinPolQ, pin2PolQ, autoOeQ;
  logic [NUM_CMP-1:0]     cmpPriPolQ, cmpSecPolQ;
  logic [FILT_CODE_W-1:0] priFiltQ, secFiltQ;
  logic [DT_W-1:0]        deadTimeQ;
  logic [NUM_PAIRS-1:0]   idleHiQ, idleLoQ;
  logic [1:0]             lockQ;
  logic                   cfgOpen;

  assign cfgOpen = (lockQ == 2'd0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      priEnQ     <= 1'b0;
      secEnQ     <= 1'b0;
      pinPolQ    <= 1'b1;
      pin2PolQ   <= 1'b1;
      cmpPriPolQ <= '1;
      cmpSecPolQ <= '1;
      priFiltQ   <= '0;
      secFiltQ   <= '0;
      deadTimeQ  <= '0;
      autoOeQ    <= 1'b0;
      idleHiQ    <= '0;
      idleLoQ    <= '0;
      lockQ      <= 2'd0;
    end else if (cfgWr && cfgOpen) begin
      priEnQ     <= cfgPriEn;
      secEnQ     <= cfgSecEn;
      pinPolQ    <= cfgPinPol;
      pin2PolQ   <= cfgPin2Pol;
      cmpPriPolQ <= cfgCmpPriPol;
      cmpSecPolQ <= cfgCmpSecPol;
      priFiltQ   <= cfgPriFilt;
      secFiltQ   <= cfgSecFilt;
      deadTimeQ  <= cfgDeadTime;
      autoOeQ    <= cfgAutoOe;
      idleHiQ    <= cfgIdleHi;
      idleLoQ    <= cfgIdleLo;
      lockQ      <= cfgLock;
    end
  end

  // Polarity correction per source, OR per channel, gated by enable
  logic [NUM_CH-1:0]                  chRaw;
  logic [NUM_CH-1:0]                  chHit;
  logic [NUM_CH-1:0][FILT_CODE_W-1:0] chCode;
  logic                               pinAct, pin2Act;
  logic [NUM_CMP-1:0]                 cmpPriAct, cmpSecAct;

  assign pinAct    = (extPin ~^ pinPolQ);
  assign pin2Act   = (extPin2 ~^ pin2PolQ);
  assign cmpPriAct = ~(cmpPri ^ cmpPriPolQ);
  assign cmpSecAct = ~(cmpSec ^ cmpSecPolQ);

  assign chRaw[0]  = priEnQ & (pinAct | (|cmpPriAct));
  assign chRaw[1]  = secEnQ & (pin2Act | (|cmpSecAct));
  assign chCode[0] = priFiltQ;
  assign chCode[1] = secFiltQ;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    brk_glitch_filter u_filt (
      .clk      (clk),
      .rstN     (rstN),
      .sampleIn (chRaw[ch]),
      .lenCode  (chCode[ch]),
      .hit      (chHit[ch])
    );
  end

  // System fault: registered once, no polarity, no filter
  logic sysQ;
  always_ff @(posedge clk) begin
    if (!rstN) sysQ <= 1'b0;
    else       sysQ <= sysFault;
  end

  assign trigPri  = chHit[0] | (sysQ & priEnQ);
  assign trigSec  = chHit[1];
  assign deadTime = deadTimeQ;
  assign autoOe   = autoOeQ;

  // Output gating per complementary pair
  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    always_comb begin
      if (strobe.outEn) begin
        pwmHiOut[p] = pwmHiIn[p];
        pwmLoOut[p] = pwmLoIn[p];
      end else if (strobe.idleMode && !strobe.dtHold) begin
        pwmHiOut[p] = idleHiQ[p];
        pwmLoOut[p] = idleLoQ[p];
      end else begin
        pwmHiOut[p] = 1'b0;
        pwmLoOut[p] = 1'b0;
      end
    end
  end

endmodule

// File: rtl/brk_control.sv
`timescale 1ns/1ps
module brk_control
  import brk_guard_pkg::*;
#(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            trigPri,
  input  logic            trigSec,
  input  logic            autoOe,
  input  logic [DT_W-1:0] deadTime,
  input  logic            updateEvt,
  input  logic            oeSetReq,
  input  logic [1:0]      flagClr,
  output guard_strobe_t   strobe,
  output logic            priFlag,
  output logic            secFlag
);

  logic            oeQ, idleQ, priFlagQ, secFlagQ;
  logic [DT_W-1:0] dtCnt;
  logic            anyTrig, manualOk, enterIdle;

  assign anyTrig   = trigPri | trigSec;
  assign manualOk  = oeSetReq & ~priFlagQ & ~secFlagQ;
  assign enterIdle = trigPri & (oeQ | ~idleQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      oeQ <= 1'b0;
    end else if (anyTrig) begin
      oeQ <= 1'b0;
    end else if ((autoOe && updateEvt) || manualOk) begin
      oeQ <= 1'b1;
    end
  end

  // Primary overrides secondary in the choice of safe state
  always_ff @(posedge clk) begin
    if (!rstN)        idleQ <= 1'b0;
    else if (trigPri) idleQ <= 1'b1;
    else if (trigSec) idleQ <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)              dtCnt <= '0;
    else if (enterIdle)     dtCnt <= deadTime;
    else if (dtCnt != '0)   dtCnt <= dtCnt - DT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      priFlagQ <= 1'b0;
      secFlagQ <= 1'b0;
    end else begin
      if (trigPri)         priFlagQ <= 1'b1;
      else if (flagClr[0]) priFlagQ <= 1'b0;
      if (trigSec)         secFlagQ <= 1'b1;
      else if (flagClr[1]) secFlagQ <= 1'b0;
    end
  end

  assign strobe.outEn    = oeQ;
  assign strobe.idleMode = idleQ;
  assign strobe.dtHold   = (dtCnt != '0);
  assign priFlag         = priFlagQ;
  assign secFlag         = secFlagQ;

endmodule

// File: rtl/pwm_break_guard.sv
`timescale 1ns/1ps
module pwm_break_guard
  import brk_guard_pkg::*;
#(
  parameter int NUM_PAIRS = 3,
  parameter int NUM_CMP   = 2,
  parameter int DT_W      = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_PAIRS-1:0] pwmHiIn,
  input  logic [NUM_PAIRS-1:0] pwmLoIn,
  input  logic                 extPin,
  input  logic                 extPin2,
  input  logic [NUM_CMP-1:0]   cmpPri,
  input  logic [NUM_CMP-1:0]   cmpSec,
  input  logic                 sysFault,
  input  logic                 cfgWr,
  input  logic                 cfgPriEn,
  input  logic                 cfgSecEn,
  input  logic                 cfgPinPol,
  input  logic                 cfgPin2Pol,
  input  logic [NUM_CMP-1:0]   cfgCmpPriPol,
  input  logic [NUM_CMP-1:0]   cfgCmpSecPol,
  input  logic [3:0]           cfgPriFilt,
  input  logic [3:0]           cfgSecFilt,
  input  logic [DT_W-1:0]      cfgDeadTime,
  input  logic                 cfgAutoOe,
  input  logic [NUM_PAIRS-1:0] cfgIdleHi,
  input  logic [NUM_PAIRS-1:0] cfgIdleLo,
  input  logic [1:0]           cfgLock,
  input  logic                 updateEvt,
  input  logic                 oeSetReq,
  input  logic [1:0]           flagClr,
  output logic [NUM_PAIRS-1:0] pwmHiOut,
  output logic [NUM_PAIRS-1:0] pwmLoOut,
  output logic                 outEn,
  output logic                 priFlag,
  output logic                 secFlag
);

  guard_strobe_t   strobe;
  logic            trigPri, trigSec, autoOe;
  logic [DT_W-1:0] deadTime;

  brk_datapath #(
    .NUM_PAIRS (NUM_PAIRS),
    .NUM_CMP   (NUM_CMP),
    .DT_W      (DT_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .pwmHiIn      (pwmHiIn),
    .pwmLoIn      (pwmLoIn),
    .extPin       (extPin),
    .extPin2      (extPin2),
    .cmpPri       (cmpPri),
    .cmpSec       (cmpSec),
    .sysFault     (sysFault),
    .cfgWr        (cfgWr),
    .cfgPriEn     (cfgPriEn),
    .cfgSecEn     (cfgSecEn),
    .cfgPinPol    (cfgPinPol),
    .cfgPin2Pol   (cfgPin2Pol),
    .cfgCmpPriPol (cfgCmpPriPol),
    .cfgCmpSecPol (cfgCmpSecPol),
    .cfgPriFilt   (cfgPriFilt),
    .cfgSecFilt   (cfgSecFilt),
    .cfgDeadTime  (cfgDeadTime),
    .cfgAutoOe    (cfgAutoOe),
    .cfgIdleHi    (cfgIdleHi),
    .cfgIdleLo    (cfgIdleLo),
    .cfgLock      (cfgLock),
    .strobe       (strobe),
    .trigPri      (trigPri),
    .trigSec      (trigSec),
    .deadTime     (deadTime),
    .autoOe       (autoOe),
    .pwmHiOut     (pwmHiOut),
    .pwmLoOut     (pwmLoOut)
  );

  brk_control #(
    .DT_W (DT_W)
  ) u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .trigPri   (trigPri),
    .trigSec   (trigSec),
    .autoOe    (autoOe),
    .deadTime  (deadTime),
    .updateEvt (updateEvt),
    .oeSetReq  (oeSetReq),
    .flagClr   (flagClr),
    .strobe    (strobe),
    .priFlag   (priFlag),
    .secFlag   (secFlag)
  );

  assign outEn = strobe.outEn;

endmodule

// File: rtl/guard_checker.sv
`timescale 1ns/1ps
module guard_checker #(
  parameter int NUM_PAIRS = 3,
  parameter int DT_W      = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 trigPri,
  input logic                 trigSec,
  input logic                 outEn,
  input logic                 priFlag,
  input logic                 secFlag,
  input logic                 autoOe,
  input logic                 updateEvt,
  input logic [DT_W-1:0]      deadTime,
  input logic [NUM_PAIRS-1:0] hiOut,
  input logic [NUM_PAIRS-1:0] loOut
);

  AST_PRI_DROPS_OE: assert property (@(posedge clk) disable iff (!rstN)
    trigPri |=> !outEn); // R4

  AST_DT_BLANK: assert property (@(posedge clk) disable iff (!rstN)
    (trigPri && outEn && deadTime != '0) |=> (hiOut == '0 && loOut == '0)); // R4

  AST_SEC_ALL_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (trigSec && !trigPri) |=> (hiOut == '0 && loOut == '0)); // R5

  AST_PRI_FLAG_SET: assert property (@(posedge clk) disable iff (!rstN)
    trigPri |=> priFlag); // R8

  AST_SEC_FLAG_SET: assert property (@(posedge clk) disable iff (!rstN)
    trigSec |=> secFlag); // R8

  AST_MANUAL_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (!outEn && (priFlag || secFlag) && !(autoOe && updateEvt)) |=> !outEn); // R8

  AST_NO_RESUME_IN_BREAK: assert property (@(posedge clk) disable iff (!rstN)
    (trigPri || trigSec) |=> !outEn); // R7

endmodule

bind pwm_break_guard guard_checker #(
  .NUM_PAIRS (NUM_PAIRS),
  .DT_W      (DT_W)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .trigPri   (trigPri),
  .trigSec   (trigSec),
  .outEn     (outEn),
  .priFlag   (priFlag),
  .secFlag   (secFlag),
  .autoOe    (autoOe),
  .updateEvt (updateEvt),
  .deadTime  (deadTime),
  .hiOut     (pwmHiOut),
  .loOut     (pwmLoOut)
);

// File: tb/pwm_break_guard_tb_top.sv
`timescale 1ns/1ps
module pwm_break_guard_tb_top;

  localparam int NP = 3;
  localparam int NC = 2;
  localparam int DW = 8;
  localparam int CLK_PERIOD = 20;

  logic          clk = 1'b0;
  logic          rstN;
  logic [NP-1:0] pwmHiIn, pwmLoIn;
  logic          extPin, extPin2, sysFault;
  logic [NC-1:0] cmpPri, cmpSec;
  logic          cfgWr, cfgPriEn, cfgSecEn, cfgPinPol, cfgPin2Pol, cfgAutoOe;
  logic [NC-1:0] cfgCmpPriPol, cfgCmpSecPol;
  logic [3:0]    cfgPriFilt, cfgSecFilt;
  logic [DW-1:0] cfgDeadTime;
  logic [NP-1:0] cfgIdleHi, cfgIdleLo;
  logic [1:0]    cfgLock;
  logic          updateEvt, oeSetReq;
  logic [1:0]    flagClr;
  logic [NP-1:0] pwmHiOut, pwmLoOut;
  logic          outEn, priFlag, secFlag;

  int nChecks = 0;
  int nFail   = 0;
  int seedTmp;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_break_guard #(.NUM_PAIRS(NP), .NUM_CMP(NC), .DT_W(DW)) dut_i (
    .clk(clk), .rstN(rstN), .pwmHiIn(pwmHiIn), .pwmLoIn(pwmLoIn),
    .extPin(extPin), .extPin2(extPin2), .cmpPri(cmpPri), .cmpSec(cmpSec),
    .sysFault(sysFault), .cfgWr(cfgWr), .cfgPriEn(cfgPriEn), .cfgSecEn(cfgSecEn),
    .cfgPinPol(cfgPinPol), .cfgPin2Pol(cfgPin2Pol), .cfgCmpPriPol(cfgCmpPriPol),
    .cfgCmpSecPol(cfgCmpSecPol), .cfgPriFilt(cfgPriFilt), .cfgSecFilt(cfgSecFilt),
    .cfgDeadTime(cfgDeadTime), .cfgAutoOe(cfgAutoOe), .cfgIdleHi(cfgIdleHi),
    .cfgIdleLo(cfgIdleLo), .cfgLock(cfgLock), .updateEvt(updateEvt),
    .oeSetReq(oeSetReq), .flagClr(flagClr), .pwmHiOut(pwmHiOut),
    .pwmLoOut(pwmLoOut), .outEn(outEn), .priFlag(priFlag), .secFlag(secFlag)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cfgDefaults();
    cfgPriEn = 0; cfgSecEn = 0; cfgPinPol = 1; cfgPin2Pol = 1;
    cfgCmpPriPol = '1; cfgCmpSecPol = '1; cfgPriFilt = 0; cfgSecFilt = 0;
    cfgDeadTime = 0; cfgAutoOe = 0; cfgIdleHi = 0; cfgIdleLo = 0; cfgLock = 0;
  endtask

  task automatic writeCfg();
    cfgWr = 1; tick(); cfgWr = 0;
  endtask

  task automatic doReset();
    rstN = 0; ticks(2); rstN = 1; tick();
  endtask

  task automatic arm();
    flagClr = 2'b11; tick(); flagClr = 2'b00;
    oeSetReq = 1; tick(); oeSetReq = 0;
  endtask

  function automatic logic expChan(input logic pin, input logic pol,
                                   input logic [NC-1:0] cmp, input logic [NC-1:0] cpol,
                                   input logic en);
    logic any;
    any = (pin == pol);
    for (int i = 0; i < NC; i++) if (cmp[i] == cpol[i]) any = 1'b1;
    return en & any;
  endfunction

  initial begin
    seedTmp = $urandom(32'h5EED_0042);
    rstN = 0; extPin = 0; extPin2 = 0; sysFault = 0; cmpPri = 0; cmpSec = 0;
    pwmHiIn = 3'b101; pwmLoIn = 3'b010; cfgWr = 0; updateEvt = 0;
    oeSetReq = 0; flagClr = 0;
    cfgDefaults();
    doReset();

    // Reset state (R11)
    check("R11", "outEn after reset", outEn, 0);
    check("R11", "flags after reset", {priFlag, secFlag}, 0);
    check("R11", "outputs after reset", {pwmHiOut, pwmLoOut}, 0);
    arm();
    check("R11", "outEn after manual request", outEn, 1);
    check("R11", "pass-through", {pwmHiOut, pwmLoOut}, {3'b101, 3'b010});

    // Random source mixes (R1, R11, R4, R5)
    for (int t = 0; t < 40; t++) begin
      logic ePri, eSec;
      cfgDefaults(); writeCfg(); ticks(2); arm();
      extPin = 1'($urandom); extPin2 = 1'($urandom);
      cmpPri = NC'($urandom); cmpSec = NC'($urandom);
      cfgPriEn = 1'($urandom); cfgSecEn = 1'($urandom);
      cfgPinPol = 1'($urandom); cfgPin2Pol = 1'($urandom);
      cfgCmpPriPol = NC'($urandom); cfgCmpSecPol = NC'($urandom);
      cfgIdleHi = NP'($urandom); cfgIdleLo = NP'($urandom);
      pwmHiIn = NP'($urandom); pwmLoIn = NP'($urandom);
      ePri = expChan(extPin, cfgPinPol, cmpPri, cfgCmpPriPol, cfgPriEn);
      eSec = expChan(extPin2, cfgPin2Pol, cmpSec, cfgCmpSecPol, cfgSecEn);
      writeCfg(); ticks(2);
      check("R1", "outEn vs source mix", outEn, !(ePri | eSec));
      if (ePri)      check("R4", "idle levels", {pwmHiOut, pwmLoOut}, {cfgIdleHi, cfgIdleLo});
      else if (eSec) check("R5", "all off", {pwmHiOut, pwmLoOut}, 0);
      else           check("R11", "pass-through", {pwmHiOut, pwmLoOut}, {pwmHiIn, pwmLoIn});
    end

    // Primary break with dead time (R4) and flags (R8)
    extPin = 0; extPin2 = 0; cmpPri = 0; cmpSec = 0;
    cfgDefaults(); cfgPriEn = 1; cfgDeadTime = 3; cfgIdleHi = 3'b001; cfgIdleLo = 3'b110;
    writeCfg(); ticks(2); arm();
    pwmHiIn = 3'b111; pwmLoIn = 3'b000;
    extPin = 1; tick();
    check("R4", "outEn one edge after", outEn, 1);
    tick();
    check("R4", "outEn two edges after", outEn, 0);
    check("R4", "blanking start", {pwmHiOut, pwmLoOut}, 0);
    ticks(2);
    check("R4", "blanking end", {pwmHiOut, pwmLoOut}, 0);
    tick();
    check("R4", "idle after dead time", {pwmHiOut, pwmLoOut}, {3'b001, 3'b110});
    check("R8", "primary flag set", priFlag, 1);
    extPin = 0; ticks(2);
    oeSetReq = 1; tick(); oeSetReq = 0;
    check("R8", "manual blocked by flag", outEn, 0);
    flagClr = 2'b01; tick(); flagClr = 0;
    check("R8", "flag cleared", priFlag, 0);
    oeSetReq = 1; tick(); oeSetReq = 0;
    check("R8", "manual accepted", outEn, 1);

    // Automatic re-enable (R7)
    extPin = 1; ticks(2); extPin = 0; ticks(2);
    updateEvt = 1; tick(); updateEvt = 0;
    check("R7", "no resume without auto", outEn, 0);
    cfgAutoOe = 1; writeCfg();
    updateEvt = 1; tick(); updateEvt = 0;
    check("R7", "auto resume with flag set", outEn, 1);
    extPin = 1; ticks(2);
    updateEvt = 1; tick(); updateEvt = 0;
    check("R7", "no resume during break", outEn, 0);
    extPin = 0; ticks(2);

    // Secondary alone, then overlap (R5, R6)
    cfgSecEn = 1; cfgDeadTime = 0; cfgAutoOe = 0; writeCfg(); ticks(2); arm();
    extPin2 = 1; ticks(2);
    check("R5", "secondary drops outEn", outEn, 0);
    check("R5", "secondary all off", {pwmHiOut, pwmLoOut}, 0);
    check("R8", "secondary flag", secFlag, 1);
    extPin = 1; ticks(2);
    check("R6", "primary wins", {pwmHiOut, pwmLoOut}, {3'b001, 3'b110});
    extPin = 0; ticks(2);
    check("R6", "back to all off", {pwmHiOut, pwmLoOut}, 0);
    extPin2 = 0; ticks(2);

    // Filter windows (R3)
    cfgSecEn = 0; cfgPriFilt = 1; writeCfg(); ticks(2); arm();
    extPin = 1; ticks(31); extPin = 0; ticks(3);
    check("R3", "31 samples at code 1", outEn, 1);
    extPin = 1; ticks(20); extPin = 0; tick(); extPin = 1; ticks(20); extPin = 0; ticks(3);
    check("R3", "restart on dropped sample", outEn, 1);
    extPin = 1; ticks(32);
    check("R3", "32 samples, not yet", outEn, 1);
    tick();
    check("R3", "32 samples trip", outEn, 0);
    extPin = 0;
    cfgPriFilt = 15; writeCfg(); ticks(2); arm();
    extPin = 1; ticks(255); extPin = 0; ticks(3);
    check("R3", "255 samples at code 15", outEn, 1);
    extPin = 1; ticks(256);
    check("R3", "256 samples, not yet", outEn, 1);
    tick();
    check("R3", "256 samples trip", outEn, 0);
    extPin = 0; ticks(2);

    // System fault bypass (R2)
    arm();
    sysFault = 1; tick(); sysFault = 0; tick();
    check("R2", "pulse trips despite long filter", outEn, 0);
    check("R2", "pulse sets primary flag", priFlag, 1);
    tick();
    cfgPriEn = 0; writeCfg(); ticks(2); arm();
    sysFault = 1; tick(); sysFault = 0; ticks(2);
    check("R2", "ignored when disabled", outEn, 1);

    // Unused pin at ground with active-low polarity (R10)
    extPin = 0; cfgPriEn = 1; cfgPinPol = 0; cfgPriFilt = 0; writeCfg(); ticks(2);
    check("R10", "grounded active-low pin trips", outEn, 0);

    // Lock (R9)
    doReset();
    cfgDefaults(); cfgPriEn = 1; cfgLock = 1; writeCfg();
    cfgPriEn = 0; cfgPinPol = 0; cfgLock = 0; writeCfg();
    cfgPriEn = 0; writeCfg(); ticks(2); arm();
    check("R9", "polarity write ignored", outEn, 1);
    extPin = 1; ticks(2);
    check("R9", "enable write ignored", outEn, 0);
    extPin = 0;
    doReset();
    cfgDefaults(); writeCfg(); ticks(2); arm();
    extPin = 1; ticks(2);
    check("R9", "reset removes lock", outEn, 1);
    extPin = 0;

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    nChecks++; nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule